// File: doc/BRIEF.md
# Rate-Adjustable Precision Time Counter

This block keeps a 64-bit time count in which one unit stands for 8 ns. The counter does not step once per reference clock. A 32-bit phase accumulator adds a programmable rate word on every reference clock, and each carry out of the accumulator advances the time by one unit. A rate word of 2^31 is the nominal speed and advances the time on every second reference clock. Larger rate words speed the clock up and smaller ones slow it down, in direct proportion. Software can use this to trim the frequency by a few percent in either direction.

Software reaches the counter through a small word-wide register port. A command word holds a persistent mode bit and a self-clearing reset strobe. The command word is accepted only when its top bit is set. A 64-bit value register is written low word first. The write to the high word commits the value, either as a new absolute time or as a signed offset added to the current time, depending on the mode bit. A read of the low word returns the live low half and freezes the high half in a snapshot, so the following high-word read gives a value that cannot be torn. A one-cycle step strobe tells downstream logic whenever the time jumps instead of advancing.

Top module: `ptp_time_counter`

## Requirements
- R1: While reset is low, the time output is 0 and the step strobe is 0. After reset, the rate reads back as 0x80000000 and the command register reads back as 0.
- R2: On every clock the rate word is added to a 32-bit accumulator. Each carry out of the accumulator adds 1 to the time. After an accumulator clear, K clocks later the time equals floor(K*rate/2^32).
- R3: A write to the command register (address 0) with bit 31 clear has no effect.
- R4: Command bit 0 selects add mode (1) or set mode (0). The bit keeps its value until a valid command rewrites it, and it reads back at bit 0 of address 0.
- R5: A valid command with bit 2 set clears both the time and the accumulator at that write edge.
- R6: A write to address 2 stages the low 32 bits of a value. A write to address 3 supplies the high 32 bits and commits the value. In set mode the committed value replaces the time.
- R7: In add mode the committed 64-bit value is added to the time as a two's-complement offset.
- R8: The step strobe is high for exactly the one cycle after a value commit or a clock reset, and low otherwise.
- R9: Reading address 2 returns the live low 32 bits of the time and snapshots the high 32 bits. Reading address 3 returns that snapshot.
- R10: The rate register sits at address 1 and reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe (arms the high-word snapshot) |
| reg_addr | input | 2 | Register address: 0 command, 1 rate, 2 value low, 3 value high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| time_o | output | 64 | Current time in 8 ns units |
| step_o | output | 1 | One-cycle strobe after a set, an add or a clock reset |

## Verification
The hardest situation to reach is a carry from the low half of the time into the high half that lands between the two word reads. Without the snapshot, that carry would make the two reads disagree. The stimulus stops the clock with a zero rate and places the time a few units below the carry. It then sets the rate to its maximum, reads the low word, and lets the carry happen before it reads the high word. The rate sweeps start from an accumulator clear, so the bench can predict the exact count for fractional ratios.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int TW = 64,
  parameter int AW = 32,
  parameter logic [AW-1:0] RATE_NOM = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [TW-1:0] time_o,
  output logic          step_o
);
  localparam int HW = TW - 32;

  logic [TW-1:0] time_q;
  logic [AW-1:0] acc_q, rate_q;
  logic [31:0]   lo_stage_q;
  logic [HW-1:0] snap_hi_q;
  logic          add_mode_q, step_q;

  logic [AW:0]   acc_sum;
  logic          cmd_ok, clk_clear, commit;
  logic [TW-1:0] wval;

  assign acc_sum   = {1'b0, acc_q} + {1'b0, rate_q};
  assign cmd_ok    = reg_wr && reg_addr == 2'd0 && reg_wdata[31];
  assign clk_clear = cmd_ok && reg_wdata[2];
  assign commit    = reg_wr && reg_addr == 2'd3;
  assign wval      = {reg_wdata[HW-1:0], lo_stage_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q     <= '0;
      acc_q      <= '0;
      rate_q     <= RATE_NOM;
      lo_stage_q <= '0;
      snap_hi_q  <= '0;
      add_mode_q <= 1'b0;
      step_q     <= 1'b0;
    end else begin
      step_q <= clk_clear || commit;
      if (clk_clear) begin
        time_q <= '0;
        acc_q  <= '0;
      end else begin
        acc_q <= acc_sum[AW-1:0];
        if (commit)
          time_q <= add_mode_q ? time_q + wval : wval;
        else if (acc_sum[AW])
          time_q <= time_q + 1'b1;
      end
      if (cmd_ok) add_mode_q <= reg_wdata[0];
      if (reg_wr && reg_addr == 2'd1) rate_q <= reg_wdata[AW-1:0];
      if (reg_wr && reg_addr == 2'd2) lo_stage_q <= reg_wdata;
      if (reg_rd && reg_addr == 2'd2) snap_hi_q <= time_q[TW-1:32];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'd0, add_mode_q};
      2'd1:    reg_rdata = rate_q;
      2'd2:    reg_rdata = time_q[31:0];
      default: reg_rdata = snap_hi_q[31:0];
    endcase
  end

  assign time_o = time_q;
  assign step_o = step_q;
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [TW-1:0] time_o,
  input logic          step_o
);
  logic jump;
  assign jump = reg_wr && (reg_addr == 2'd3 ||
                (reg_addr == 2'd0 && reg_wdata[31] && reg_wdata[2]));

  // R8
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  // R8
  step_after_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> step_o);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[31] && reg_wdata[2]) |=> time_o == '0);

  // R2
  advance_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jump |=> (time_o == $past(time_o) || time_o == $past(time_o) + 1'b1));

  // R3
  invalid_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !reg_wdata[31]) |=> !step_o);
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .time_o(time_o), .step_o(step_o)
);

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_o;
  logic        step_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter i_ptp_time_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_o(time_o), .step_o(step_o)
  );

  // {expected[63:48], clocks[47:32], rate[31:0]}  (R2)
  localparam logic [63:0] VEC [5] = '{
    {16'd10, 16'd20, 32'h8000_0000},
    {16'd19, 16'd20, 32'hFFFF_FFFF},
    {16'd5,  16'd20, 32'h4000_0000},
    {16'd16, 16'd32, 32'h8400_0000},
    {16'd31, 16'd64, 32'h7C00_0000}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    check("R1 time", time_o, 64'd0);
    check("R1 step", {63'd0, step_o}, 64'd0);
    rst_n = 1'b1;
    rd(2'd1, d); check("R1 R10 rate", {32'd0, d}, 64'h8000_0000);
    rd(2'd0, d); check("R1 mode", {32'd0, d}, 64'd0);

    for (int i = 0; i < 5; i++) begin
      wr(2'd1, VEC[i][31:0]);
      rd(2'd1, d); check("R10 rate readback", {32'd0, d}, {32'd0, VEC[i][31:0]});
      wr(2'd0, 32'h8000_0004);
      check("R5 clear", time_o, 64'd0);
      check("R8 step after clear", {63'd0, step_o}, 64'd1);
      repeat (int'(VEC[i][47:32])) @(negedge clk);
      check("R2 rate count", time_o, {48'd0, VEC[i][63:48]});
    end

    wr(2'd1, 32'd0);
    wr(2'd0, 32'h8000_0000);
    wr(2'd2, 32'h0000_1234);
    check("R8 no step on low stage", {63'd0, step_o}, 64'd0);
    wr(2'd3, 32'h0000_0005);
    check("R6 set", time_o, 64'h5_0000_1234);
    check("R8 step after set", {63'd0, step_o}, 64'd1);
    @(negedge clk);
    check("R8 step one cycle", {63'd0, step_o}, 64'd0);

    wr(2'd0, 32'h8000_0001);
    rd(2'd0, d); check("R4 add mode readback", {32'd0, d}, 64'd1);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R7 add minus one", time_o, 64'h5_0000_1233);
    wr(2'd2, 32'hFFFF_FFF0);
    wr(2'd3, 32'h0000_0000);
    check("R7 add with carry", time_o, 64'h6_0000_1223);
    wr(2'd2, 32'd1);
    wr(2'd3, 32'd0);
    check("R4 mode persists", time_o, 64'h6_0000_1224);

    t0 = time_o;
    wr(2'd0, 32'h0000_0004);
    check("R3 invalid reset ignored", time_o, t0);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); check("R3 invalid mode write ignored", {32'd0, d}, 64'd1);

    wr(2'd0, 32'h8000_0004);
    wr(2'd0, 32'h8000_0000);
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'h0000_0002);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R9 live low", {32'd0, d}, 64'hFFFF_FFFE);
    repeat (10) @(negedge clk);
    check("R9 carry happened", {32'd0, time_o[63:32]}, 64'd3);
    rd(2'd3, d); check("R9 snapshot high", {32'd0, d}, 64'd2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule